// File: doc/BRIEF.md
# SMM Memory Region Access Controller

This block holds the two configuration registers that govern system-management memory and, for every memory access presented to it, picks one of three destinations: main DRAM, the PCI/legacy bus, or a sink that answers reads with all ones and drops writes. The choice depends on the access address, on whether the requester is running in system-management mode (SMM), and on the size of memory installed below 4 GB.

Three regions are controlled. The first is the 128 KB legacy window at 0xA0000. The second is a 128 KB high alias at 0xFEDA0000 that is translated onto DRAM at 0xA0000. The third is a segment of selectable size at the top of low memory. A one-way lock bit closes the window to non-SMM code and freezes both registers until the next reset. Any address outside the controlled regions goes to DRAM if it lies below the memory top and to the bus otherwise.

The route is combinational from the current register state, so a register write shows in the route in the cycle after the clock edge that commits it.

Top module: `smm_region_ctrl`

## Requirements
- R1: After reset the control register holds global-enable=1, open=0, lock=0 and the extended register holds all zeros. So an SMM access to 0xA0000 goes to DRAM and a non-SMM access to it goes to the bus.
- R2: Writing lock=1 (control bit 2) sets the lock, and no write clears it before reset. While the lock is set, the open bit (control bit 0) reads as 0, even when the same write sets open=1.
- R3: Once the lock is set, writes to either register have no effect until reset. A write in the same cycle that sets the lock is still taken under the unlocked mask, including its extended-register lane.
- R4: For non-SMM accesses to 0xA0000–0xBFFFF, the route is DRAM when open=1 and high-enable=0. It is the bus when open=1 and high-enable=1, and the bus when open=0. High-enable is extended bit 0.
- R5: A non-SMM access to 0xFEDA0000–0xFEDBFFFF with open=1 and high-enable=1 goes to DRAM, and route_addr is the address minus 0xFEDA0000 plus 0xA0000. In every other case that window gets the default routing.
- R6: For SMM accesses with global-enable=1 (control bit 1), the legacy window goes to DRAM when high-enable=0 and the high alias goes to DRAM (translated) when high-enable=1. An SMM region that is not mapped, including both regions when global-enable=0, is routed as a non-SMM access would be.
- R7: The top segment exists only when segment-enable (extended bit 1) is 1. Its size code (extended bits 3:2) selects 0=1 MB, 1=2 MB, 2=8 MB, and 3 gives size 0, which means no segment.
- R8: A non-SMM access to [mem_top − size, mem_top) is routed to the sink (code 2).
- R9: An SMM access to the top segment is routed to DRAM with route_addr equal to the access address.
- R10: Uncontrolled addresses are routed to DRAM (code 0) below mem_top and to the bus (code 1) at or above it. route_addr equals the access address except in the translated alias case.
- R11: A committed register write changes the route in the next cycle.
- R12: cfg_be[0] enables the control lane cfg_wdata[2:0] and cfg_be[1] enables the extended lane cfg_wdata[6:3]. A lane whose enable is 0 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Register write strobe |
| cfg_be | input | 2 | Lane enables: bit 0 control, bit 1 extended |
| cfg_wdata | input | 7 | [2:0] control {lock, global-enable, open}; [6:3] extended {size[1:0], seg-enable, high-enable} |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Access issued in system-management mode |
| mem_top | input | 32 | Bytes of memory below 4 GB |
| route | output | 2 | 0 DRAM, 1 bus, 2 sink |
| route_addr | output | 32 | Address presented to the chosen target |

## Verification
Two functions can land in the same clock edge: setting the lock and writing other register bits, in either lane. The bench provokes this with one write that sets lock, open and high-enable together. It then judges the result through routing alone. The legacy window must go to the bus because open was forced low. The SMM alias must reach DRAM, which proves the extended lane was accepted in that same cycle. Later writes that try to reopen or clear must leave every route unchanged.

// File: rtl/smm_rc_pkg.sv
package smm_rc_pkg;

  typedef enum logic [1:0] {
    RT_DRAM = 2'd0,
    RT_BUS  = 2'd1,
    RT_SINK = 2'd2
  } route_e;

  // control lane: bit2 lock, bit1 global enable, bit0 open
  typedef struct packed {
    logic lock;
    logic glob_en;
    logic open;
  } ctl_t;

  // extended lane: [3:2] size code, [1] segment enable, [0] high enable
  typedef struct packed {
    logic [1:0] seg_sz;
    logic       seg_en;
    logic       high_en;
  } ext_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int EXT_W = $bits(ext_t);

  localparam ctl_t CTL_RST = '{lock: 1'b0, glob_en: 1'b1, open: 1'b0};
  localparam ext_t EXT_RST = '{seg_sz: 2'd0, seg_en: 1'b0, high_en: 1'b0};

endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
  import smm_rc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_be,
  input  logic [CTL_W+EXT_W-1:0] cfg_wdata,
  output ctl_t                   ctl_q,
  output ext_t                   ext_q
);

  ctl_t ctl_d;
  ext_t ext_d;
  logic ctl_en;
  logic ext_en;
  ctl_t ctl_wr;

  // Lanes are accepted only while unlocked; the mask is sampled before the write.
  assign ctl_en = cfg_we & cfg_be[0] & ~ctl_q.lock;
  assign ext_en = cfg_we & cfg_be[1] & ~ctl_q.lock;
  assign ctl_wr = ctl_t'(cfg_wdata[CTL_W-1:0]);

  always_comb begin
    ctl_d = ctl_q;
    ext_d = ext_q;
    if (ctl_en) begin
      ctl_d.lock    = ctl_wr.lock;
      ctl_d.glob_en = ctl_wr.glob_en;
      ctl_d.open    = ctl_wr.open & ~ctl_wr.lock;
    end
    if (ext_en) begin
      ext_d = ext_t'(cfg_wdata[CTL_W+EXT_W-1:CTL_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= EXT_RST;
    end else if (ext_en) begin
      ext_q <= ext_d;
    end
  end

  // R2: lock is one-way
  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> ctl_q.lock);

  // R2: open never coexists with lock
  p_open_low_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |-> !ctl_q.open);

  // R3: both registers frozen once locked
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> ($stable(ctl_q) && $stable(ext_q)));

endmodule

// File: rtl/smm_win_match.sv
module smm_win_match #(
  parameter int          AW     = 32,
  parameter logic [31:0] BASE   = 32'h000A_0000,
  parameter logic [31:0] SIZE   = 32'h0002_0000,
  parameter logic [31:0] TARGET = 32'h000A_0000
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] xlat
);

  localparam logic [AW-1:0] BASE_A   = AW'(BASE);
  localparam logic [AW-1:0] LIMIT_A  = AW'(BASE + SIZE);
  localparam logic [AW-1:0] TARGET_A = AW'(TARGET);

  assign hit  = (addr >= BASE_A) && (addr < LIMIT_A);
  assign xlat = TARGET_A + (addr - BASE_A);

endmodule

// File: rtl/smm_route_decode.sv
module smm_route_decode
  import smm_rc_pkg::*;
#(
  parameter int          AW          = 32,
  parameter logic [31:0] LEGACY_BASE = 32'h000A_0000,
  parameter logic [31:0] ALIAS_BASE  = 32'hFEDA_0000,
  parameter logic [31:0] WIN_SIZE    = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl_q,
  input  ext_t          ext_q,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_smm,
  input  logic [AW-1:0] mem_top,
  output route_e        route,
  output logic [AW-1:0] route_addr
);

  localparam int          NWIN = 2;
  localparam int          W_LEG = 0;
  localparam int          W_ALI = 1;
  localparam logic [AW-1:0] MB = AW'(32'h0010_0000);

  logic [NWIN-1:0] win_hit;
  logic [AW-1:0]   win_xlat [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [31:0] WB = (g == W_LEG) ? LEGACY_BASE : ALIAS_BASE;
    smm_win_match #(
      .AW(AW), .BASE(WB), .SIZE(WIN_SIZE), .TARGET(LEGACY_BASE)
    ) u_win (
      .addr(acc_addr),
      .hit (win_hit[g]),
      .xlat(win_xlat[g])
    );
  end

  logic [AW-1:0] seg_size;
  logic [AW-1:0] seg_base;
  logic          seg_hit;

  always_comb begin
    seg_size = '0;
    if (ext_q.seg_en) begin
      unique case (ext_q.seg_sz)
        2'd0:    seg_size = MB;
        2'd1:    seg_size = MB << 1;
        2'd2:    seg_size = MB << 3;
        default: seg_size = '0;
      endcase
    end
  end

  assign seg_base = mem_top - seg_size;
  assign seg_hit  = (seg_size != '0) && (acc_addr >= seg_base) && (acc_addr < mem_top);

  route_e plain_rt;
  logic   plain_ali;

  // view of a non-SMM requester
  always_comb begin
    plain_ali = 1'b0;
    if (seg_hit) begin
      plain_rt = RT_SINK;
    end else if (win_hit[W_LEG]) begin
      plain_rt = (ctl_q.open && !ext_q.high_en) ? RT_DRAM : RT_BUS;
    end else if (win_hit[W_ALI] && ctl_q.open && ext_q.high_en) begin
      plain_rt  = RT_DRAM;
      plain_ali = 1'b1;
    end else begin
      plain_rt = (acc_addr < mem_top) ? RT_DRAM : RT_BUS;
    end
  end

  logic sel_ali;

  always_comb begin
    route   = plain_rt;
    sel_ali = plain_ali;
    if (acc_smm) begin
      if (seg_hit) begin
        route   = RT_DRAM;
        sel_ali = 1'b0;
      end else if (ctl_q.glob_en && !ext_q.high_en && win_hit[W_LEG]) begin
        route   = RT_DRAM;
        sel_ali = 1'b0;
      end else if (ctl_q.glob_en && ext_q.high_en && win_hit[W_ALI]) begin
        route   = RT_DRAM;
        sel_ali = 1'b1;
      end
    end
  end

  assign route_addr = sel_ali ? win_xlat[W_ALI] : acc_addr;

  // R8: the sink only ever serves non-SMM requesters
  p_no_sink_smm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_smm |-> (route != RT_SINK));

  // R9: SMM segment accesses reach DRAM untranslated
  p_seg_smm_dram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_smm && seg_hit) |-> (route == RT_DRAM && route_addr == acc_addr));

  // R5: translation only inside the alias window toward DRAM
  p_alias_xlat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route_addr != acc_addr) |-> (win_hit[W_ALI] && route == RT_DRAM));

  // R10: route code is always one of the three defined values
  p_route_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    route inside {RT_DRAM, RT_BUS, RT_SINK});

endmodule

// File: rtl/smm_region_ctrl.sv
module smm_region_ctrl
  import smm_rc_pkg::*;
#(
  parameter int          AW          = 32,
  parameter logic [31:0] LEGACY_BASE = 32'h000A_0000,
  parameter logic [31:0] ALIAS_BASE  = 32'hFEDA_0000,
  parameter logic [31:0] WIN_SIZE    = 32'h0002_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_be,
  input  logic [CTL_W+EXT_W-1:0] cfg_wdata,
  input  logic [AW-1:0]          acc_addr,
  input  logic                   acc_smm,
  input  logic [AW-1:0]          mem_top,
  output logic [1:0]             route,
  output logic [AW-1:0]          route_addr
);

  ctl_t   ctl_q;
  ext_t   ext_q;
  route_e rt;

  smm_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_be   (cfg_be),
    .cfg_wdata(cfg_wdata),
    .ctl_q    (ctl_q),
    .ext_q    (ext_q)
  );

  smm_route_decode #(
    .AW(AW), .LEGACY_BASE(LEGACY_BASE), .ALIAS_BASE(ALIAS_BASE), .WIN_SIZE(WIN_SIZE)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_q     (ctl_q),
    .ext_q     (ext_q),
    .acc_addr  (acc_addr),
    .acc_smm   (acc_smm),
    .mem_top   (mem_top),
    .route     (rt),
    .route_addr(route_addr)
  );

  assign route = rt;

endmodule

// File: tb/smm_region_ctrl_bench.sv
module smm_region_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] DR = 2'd0, BU = 2'd1, SK = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [6:0]  cfg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_smm = 1'b0;
  logic [31:0] mem_top = 32'h8000_0000;
  logic [1:0]  route;
  logic [31:0] route_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]  rt;
    logic [31:0] ad;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_region_ctrl u_smm_region_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_smm(acc_smm),
    .mem_top(mem_top), .route(route), .route_addr(route_addr)
  );

  // monitor: compare one item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (route !== e.rt || route_addr !== e.ad) begin
          n_bad++;
          $display("FAIL %s: route=%0d addr=%h expected route=%0d addr=%h",
                   e.tag, route, route_addr, e.rt, e.ad);
        end
      end
    end
  end

  task automatic probe(input logic [31:0] a, input logic smm,
                       input logic [1:0] rt, input logic [31:0] xa, input string tag);
    exp_t e;
    @(negedge clk);
    acc_addr = a;
    acc_smm  = smm;
    e.rt = rt; e.ad = xa; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [1:0] be, input logic [2:0] ctl, input logic [3:0] ext);
    @(negedge clk);
    cfg_we = 1'b1; cfg_be = be; cfg_wdata = {ext, ctl};
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 defaults
    probe(32'h000A_0000, 1'b0, BU, 32'h000A_0000, "R1 legacy non-SMM");
    probe(32'h000A_0000, 1'b1, DR, 32'h000A_0000, "R1 legacy SMM");
    probe(32'hFEDA_0000, 1'b0, BU, 32'hFEDA_0000, "R1 alias hidden");
    probe(32'h7FF0_0000, 1'b0, DR, 32'h7FF0_0000, "R7 segment off");
    // R10 default routing
    probe(32'h0000_1000, 1'b0, DR, 32'h0000_1000, "R10 low DRAM");
    probe(32'h9000_0000, 1'b0, BU, 32'h9000_0000, "R10 above top");
    drain();

    // R4 / R11: open, no high
    wr(2'b01, 3'b011, 4'h0);
    probe(32'h000B_FFFF, 1'b0, DR, 32'h000B_FFFF, "R4 R11 open low");
    probe(32'h000C_0000, 1'b0, DR, 32'h000C_0000, "R10 past window");
    probe(32'hFEDA_0000, 1'b0, BU, 32'hFEDA_0000, "R5 alias needs high");
    drain();

    // R5 / R6: high enable
    wr(2'b10, 3'b000, 4'h1);
    probe(32'h000A_0000, 1'b0, BU, 32'h000A_0000, "R4 open high");
    probe(32'hFEDA_1234, 1'b0, DR, 32'h000A_1234, "R5 alias xlat");
    probe(32'hFEDA_1234, 1'b1, DR, 32'h000A_1234, "R6 SMM alias");
    probe(32'h000A_0000, 1'b1, BU, 32'h000A_0000, "R6 SMM legacy unmapped");
    drain();

    // R6: global enable off, open off
    wr(2'b01, 3'b000, 4'h0);
    probe(32'hFEDA_1234, 1'b1, BU, 32'hFEDA_1234, "R6 gen off alias");
    probe(32'h000A_0000, 1'b1, BU, 32'h000A_0000, "R6 gen off legacy");
    probe(32'h000A_0000, 1'b0, BU, 32'h000A_0000, "R4 closed");
    drain();

    // R7 / R8 / R9 segment sizes
    wr(2'b10, 3'b000, 4'b0010);
    probe(32'h7FF0_0000, 1'b0, SK, 32'h7FF0_0000, "R8 1MB base");
    probe(32'h7FEF_FFFF, 1'b0, DR, 32'h7FEF_FFFF, "R7 1MB below");
    probe(32'h7FFF_FFFF, 1'b0, SK, 32'h7FFF_FFFF, "R8 1MB top");
    probe(32'h8000_0000, 1'b0, BU, 32'h8000_0000, "R10 at top");
    probe(32'h7FF0_0000, 1'b1, DR, 32'h7FF0_0000, "R9 SMM segment");
    drain();
    wr(2'b10, 3'b000, 4'b0110);
    probe(32'h7FE0_0000, 1'b0, SK, 32'h7FE0_0000, "R7 2MB base");
    probe(32'h7FDF_FFFF, 1'b0, DR, 32'h7FDF_FFFF, "R7 2MB below");
    drain();
    wr(2'b10, 3'b000, 4'b1010);
    probe(32'h7F80_0000, 1'b0, SK, 32'h7F80_0000, "R7 8MB base");
    probe(32'h7F7F_FFFF, 1'b0, DR, 32'h7F7F_FFFF, "R7 8MB below");
    drain();
    wr(2'b10, 3'b000, 4'b1110);
    probe(32'h7FFF_FFFF, 1'b0, DR, 32'h7FFF_FFFF, "R7 code3 size0");
    drain();
    wr(2'b10, 3'b000, 4'b0100);
    probe(32'h7FFF_FFFF, 1'b0, DR, 32'h7FFF_FFFF, "R7 disabled");
    drain();

    // R12: control lane only, extended lane data ignored
    wr(2'b01, 3'b011, 4'h1);
    probe(32'h000A_0000, 1'b0, DR, 32'h000A_0000, "R12 ext lane kept");
    drain();

    // R2 / R3: lock with open and high in the same write
    wr(2'b11, 3'b111, 4'h1);
    probe(32'h000A_0000, 1'b0, BU, 32'h000A_0000, "R2 open forced low");
    probe(32'hFEDA_0040, 1'b0, BU, 32'hFEDA_0040, "R2 alias hidden");
    probe(32'hFEDA_0040, 1'b1, DR, 32'h000A_0040, "R3 same-cycle ext taken");
    drain();
    wr(2'b11, 3'b011, 4'h0);
    probe(32'h000A_0000, 1'b0, BU, 32'h000A_0000, "R3 open write ignored");
    probe(32'hFEDA_0040, 1'b1, DR, 32'h000A_0040, "R3 ext write ignored");
    probe(32'h000A_0000, 1'b1, BU, 32'h000A_0000, "R2 lock kept");
    drain();

    // R1 reset clears lock
    do_reset();
    probe(32'h000A_0000, 1'b1, DR, 32'h000A_0000, "R1 after re-reset");
    probe(32'hFEDA_0040, 1'b1, BU, 32'hFEDA_0040, "R1 high cleared");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule